// File: doc/BRIEF.md
# Co-processor Issue and Timeout Monitor

This block sits on the CPU side of a custom-instruction co-processor port. It accepts one decoded custom operation at a time through a valid/ready request port. The request carries the instruction-type code and the two function fields. The block fires a single-cycle start strobe at the attached co-processors and forwards the type and function fields to them, holding those fields stable. It then waits for a completion flag.

Completion is announced one cycle ahead of the data. When any co-processor raises its valid flag, the block samples the merged result bus on the following cycle and presents it as a one-cycle write-back pulse. Several co-processors share the result path. Each keeps its result bus at zero except in its one result cycle, so the buses are merged with a bitwise OR. A watchdog bounds the wait. If no valid flag arrives in time, the operation is dropped and a one-cycle illegal-instruction exception pulse is raised. A CPU trap also aborts the operation at any point, silently.

Back-pressure rules: `req_ready` is high only while the block is idle. A request presented while `req_ready` is low is not taken and has no effect. The requester may hold it until `req_ready` returns. The write-back and exception outputs are pulses and cannot be stalled.

Top module: `cpx_issue_monitor`

## Requirements
- R1: `req_ready` equals the inverse of `busy`. A request with `req_valid` high while busy is ignored: it produces no strobe and leaves the forwarded fields unchanged.
- R2: A request accepted at a clock edge makes `cp_start` high for exactly the next cycle, and `busy` rises in that same cycle.
- R3: `cp_kind` carries the request's 2-bit type code, which is opcode bits 6:5 (the four custom opcodes give codes 00, 01, 10 and 11). `cp_funct3` and `cp_funct7` carry the 3-bit and 7-bit function fields unchanged. All three hold steady while busy.
- R4: If the merged valid flag is high in cycle c of an operation and no trap occurs in cycles c or c+1, then the merged result present in cycle c+1 appears on `wb_data` with `wb_valid` high in cycle c+2, and `busy` is low in cycle c+2.
- R5: The merged result is the bitwise OR of all NUM_CP result buses, and the merged valid flag is the OR of all valid flags.
- R6: `wb_data` is all zeros whenever `wb_valid` is low.
- R7: Call the cycle in which `cp_start` is high cycle s. A valid flag in any of cycles s to s+TIMEOUT-1 completes the operation. If none arrives, `exc_illegal` is high in cycle s+TIMEOUT and `busy` is low in that cycle.
- R8: `exc_illegal` is a single-cycle pulse and is never high together with `wb_valid`.
- R9: `trap_i` high in a busy cycle ends the operation. `busy` is low in the next cycle, and neither `wb_valid` nor `exc_illegal` follows. This also holds for a trap in the cycle after valid.
- R10: Valid flags and result data that arrive while idle are ignored: no write-back, exception or busy follows.
- R11: `rst_n` low clears the block at once, without waiting for a clock edge. `busy`, `cp_start`, `wb_valid` and `exc_illegal` go low, `wb_data` goes to zero and `req_ready` goes high.
- R12: A valid flag in the last window cycle (s+TIMEOUT-1) takes priority over the watchdog: the operation writes back and raises no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | High when a request can be taken (idle) |
| req_op_hi | input | 2 | Opcode bits 6:5, the instruction-type code |
| req_funct3 | input | 3 | 3-bit function field |
| req_funct7 | input | 7 | 7-bit function field |
| trap_i | input | 1 | CPU trap pending; aborts the operation |
| cp_start | output | 1 | One-cycle start strobe to the co-processors |
| cp_kind | output | 2 | Forwarded type code |
| cp_funct3 | output | 3 | Forwarded 3-bit function field |
| cp_funct7 | output | 7 | Forwarded 7-bit function field |
| cp_valid | input | NUM_CP | Completion flags, one per co-processor, one cycle before the data |
| cp_result | input | NUM_CP*DATA_W | Concatenated result buses, zero when idle |
| busy | output | 1 | Operation in flight (stall request) |
| wb_valid | output | 1 | Write-back pulse |
| wb_data | output | DATA_W | Write-back result, zero outside the pulse |
| exc_illegal | output | 1 | Illegal-instruction exception pulse on timeout |

## Verification
Two pairs of events can fall in the same cycle. A valid flag can land in the final watchdog cycle, exactly when the counter expires. A trap can land in the capture cycle right after valid. The bench forces both cases with directed completion delays of TIMEOUT-1 and traps placed at valid+1. Random delays and trap positions cover the cases around them. The outcome is judged at the ports. The first case must give a write-back and no exception. The second must give neither a write-back nor an exception, and `busy` must drop one cycle after the trap.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int KIND_W = 2;
  localparam int F3_W   = 3;
  localparam int F7_W   = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TAKE = 2'd2
  } cpx_state_e;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [F3_W-1:0]   f3;
    logic [F7_W-1:0]   f7;
  } cpx_op_t;
endpackage

// File: rtl/cpx_result_merge.sv
module cpx_result_merge #(
  parameter int NUM_CP = 3,
  parameter int DATA_W = 32
) (
  input  logic [NUM_CP-1:0]        cp_valid,
  input  logic [NUM_CP*DATA_W-1:0] cp_result,
  output logic                     any_valid,
  output logic [DATA_W-1:0]        merged
);
  logic [DATA_W-1:0] chain [0:NUM_CP];

  assign chain[0] = '0;
  for (genvar g = 0; g < NUM_CP; g++) begin : g_or
    assign chain[g+1] = chain[g] | cp_result[g*DATA_W +: DATA_W];
  end

  assign merged    = chain[NUM_CP];
  assign any_valid = |cp_valid;
endmodule

// File: rtl/cpx_watchdog.sv
module cpx_watchdog #(
  parameter int LIMIT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  // R7: the window counter never passes its last value
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R7: a freshly cleared window is never already expired
  assert_clear_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !expired);
endmodule

// File: rtl/cpx_issue_ctrl.sv
module cpx_issue_ctrl
  import cpx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  cpx_op_t           req_op,
  input  logic              trap_i,
  input  logic              any_valid,
  input  logic [DATA_W-1:0] merged,
  input  logic              wd_expired,
  output logic              req_ready,
  output logic              cp_start,
  output cpx_op_t           cp_op,
  output logic              busy,
  output logic              wd_clear,
  output logic              wd_run,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data,
  output logic              exc_illegal
);
  cpx_state_e state;
  logic       accept;

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign wd_clear  = accept;
  assign wd_run    = (state == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cp_start    <= 1'b0;
      cp_op       <= '0;
      wb_valid    <= 1'b0;
      wb_data     <= '0;
      exc_illegal <= 1'b0;
    end else begin
      cp_start    <= 1'b0;
      wb_valid    <= 1'b0;
      wb_data     <= '0;
      exc_illegal <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_WAIT;
            cp_start <= 1'b1;
            cp_op    <= req_op;
          end
        end
        ST_WAIT: begin
          if (trap_i)          state <= ST_IDLE;
          else if (any_valid)  state <= ST_TAKE;
          else if (wd_expired) begin
            state       <= ST_IDLE;
            exc_illegal <= 1'b1;
          end
        end
        ST_TAKE: begin
          state <= ST_IDLE;
          if (!trap_i) begin
            wb_valid <= 1'b1;
            wb_data  <= merged;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: strobe lasts one cycle
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cp_start |=> !cp_start);
  // R2: an accepted request gives strobe and busy next cycle
  assert_accept_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cp_start && busy));
  // R1: requests while busy never cause a strobe
  assert_busy_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> !cp_start);
  // R3: forwarded fields steady while busy
  assert_fields_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cp_op));
  // R4: write-back only two cycles after a valid flag
  assert_wb_after_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(any_valid, 2));
  // R6: result bus is zero outside the pulse
  assert_wb_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> (wb_data == '0));
  // R8: exception is a single pulse and excludes write-back
  assert_exc_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_illegal |=> !exc_illegal);
  assert_exc_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_illegal && wb_valid));
  // R9: a trap while busy leaves nothing behind
  assert_trap_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trap_i) |=> (!busy && !wb_valid && !exc_illegal));
  // R10: an idle cycle without request stays quiet
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> (!busy && !wb_valid && !exc_illegal));
  // R12: valid in the expiring cycle wins over the watchdog
  assert_valid_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_run && any_valid && wd_expired && !trap_i) |=> !exc_illegal);
endmodule

// File: rtl/cpx_issue_monitor.sv
module cpx_issue_monitor
  import cpx_pkg::*;
#(
  parameter int NUM_CP  = 3,
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [KIND_W-1:0]        req_op_hi,
  input  logic [F3_W-1:0]          req_funct3,
  input  logic [F7_W-1:0]          req_funct7,
  input  logic                     trap_i,
  output logic                     cp_start,
  output logic [KIND_W-1:0]        cp_kind,
  output logic [F3_W-1:0]          cp_funct3,
  output logic [F7_W-1:0]          cp_funct7,
  input  logic [NUM_CP-1:0]        cp_valid,
  input  logic [NUM_CP*DATA_W-1:0] cp_result,
  output logic                     busy,
  output logic                     wb_valid,
  output logic [DATA_W-1:0]        wb_data,
  output logic                     exc_illegal
);
  cpx_op_t           req_op, cp_op;
  logic              any_valid, wd_expired, wd_clear, wd_run;
  logic [DATA_W-1:0] merged;

  assign req_op    = '{kind: req_op_hi, f3: req_funct3, f7: req_funct7};
  assign cp_kind   = cp_op.kind;
  assign cp_funct3 = cp_op.f3;
  assign cp_funct7 = cp_op.f7;

  cpx_result_merge #(.NUM_CP(NUM_CP), .DATA_W(DATA_W)) u_merge (
    .cp_valid (cp_valid),
    .cp_result(cp_result),
    .any_valid(any_valid),
    .merged   (merged)
  );

  cpx_watchdog #(.LIMIT(TIMEOUT)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (wd_clear),
    .run    (wd_run),
    .expired(wd_expired)
  );

  cpx_issue_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .trap_i     (trap_i),
    .any_valid  (any_valid),
    .merged     (merged),
    .wd_expired (wd_expired),
    .req_ready  (req_ready),
    .cp_start   (cp_start),
    .cp_op      (cp_op),
    .busy       (busy),
    .wd_clear   (wd_clear),
    .wd_run     (wd_run),
    .wb_valid   (wb_valid),
    .wb_data    (wb_data),
    .exc_illegal(exc_illegal)
  );

  // R5: write-back data equals the OR of the buses one cycle earlier
  assert_merge_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data == $past(merged)));
endmodule

// File: tb/sim_cpx_issue_monitor.sv
`timescale 1ns/1ps
module sim_cpx_issue_monitor;
  localparam int NUM_CP = 3;
  localparam int W      = 32;
  localparam int LIMIT  = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid, req_ready, trap_i, cp_start, busy, wb_valid, exc_illegal;
  logic [1:0] req_op_hi, cp_kind;
  logic [2:0] req_funct3, cp_funct3;
  logic [6:0] req_funct7, cp_funct7;
  logic [NUM_CP-1:0] cp_valid;
  logic [NUM_CP*W-1:0] cp_result;
  logic [W-1:0] wb_data;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  cpx_issue_monitor #(.NUM_CP(NUM_CP), .DATA_W(W), .TIMEOUT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op_hi(req_op_hi), .req_funct3(req_funct3), .req_funct7(req_funct7),
    .trap_i(trap_i), .cp_start(cp_start), .cp_kind(cp_kind),
    .cp_funct3(cp_funct3), .cp_funct7(cp_funct7), .cp_valid(cp_valid),
    .cp_result(cp_result), .busy(busy), .wb_valid(wb_valid),
    .wb_data(wb_data), .exc_illegal(exc_illegal)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; trap_i = 1'b0; cp_valid = '0; cp_result = '0;
  endtask

  // Bench model of the expected end: 0 = abort, 1 = write-back, 2 = exception
  function automatic int end_kind(input int d, input int tr);
    if (tr >= 0 && (d < 0 || tr <= d + 1)) return 0;
    if (d >= 0 && d < LIMIT) return 1;
    return 2;
  endfunction

  function automatic int end_cycle(input int d, input int tr);
    int k = end_kind(d, tr);
    if (k == 0) return tr + 1;
    if (k == 1) return d + 2;
    return LIMIT;
  endfunction

  // d: cycle after the strobe cycle in which valid rises (-1 = never)
  // tr: cycle of a trap (-1 = none)
  task automatic do_op(input logic [1:0] kh, input logic [2:0] f3, input logic [6:0] f7,
                       input int d, input int tr, input logic [W-1:0] data, input bit stray);
    int e = end_cycle(d, tr);
    int kind = end_kind(d, tr);
    logic [W-1:0] m0 = $urandom;
    logic [W-1:0] m1 = ~m0 & $urandom;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready when idle", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_op_hi = kh; req_funct3 = f3; req_funct7 = f7;
    for (int i = 0; i <= e + 2; i++) begin
      @(negedge clk);
      if (i < e) begin
        chk(busy == 1'b1, "R2 busy during operation", {63'd0, busy}, 64'd1);
        chk(req_ready == 1'b0, "R1 ready low while busy", {63'd0, req_ready}, 64'd0);
        chk(cp_start == (i == 0), "R2 start strobe one cycle", {63'd0, cp_start}, {63'd0, i == 0});
        chk(wb_valid == 1'b0, "R4 no early write-back", {63'd0, wb_valid}, 64'd0);
        chk(exc_illegal == 1'b0, "R7 no early exception", {63'd0, exc_illegal}, 64'd0);
        chk({cp_kind, cp_funct3, cp_funct7} == {kh, f3, f7}, "R3 forwarded fields held",
            {52'd0, cp_kind, cp_funct3, cp_funct7}, {52'd0, kh, f3, f7});
      end else if (i == e) begin
        chk(busy == 1'b0, "R4/R7/R9 busy low at end", {63'd0, busy}, 64'd0);
        if (kind == 1) begin
          chk(wb_valid == 1'b1, "R4 write-back pulse", {63'd0, wb_valid}, 64'd1);
          chk(wb_data == data, "R5 merged write-back data", {32'd0, wb_data}, {32'd0, data});
          chk(exc_illegal == 1'b0, "R12 no exception with write-back", {63'd0, exc_illegal}, 64'd0);
        end else if (kind == 2) begin
          chk(exc_illegal == 1'b1, "R7 timeout exception", {63'd0, exc_illegal}, 64'd1);
          chk(wb_valid == 1'b0, "R8 no write-back on exception", {63'd0, wb_valid}, 64'd0);
        end else begin
          chk(wb_valid == 1'b0 && exc_illegal == 1'b0, "R9 trap abort silent",
              {62'd0, wb_valid, exc_illegal}, 64'd0);
        end
      end else begin
        chk(!busy && !wb_valid && !exc_illegal && !cp_start, "R8/R10 quiet after end",
            {60'd0, busy, wb_valid, exc_illegal, cp_start}, 64'd0);
      end
      chk(wb_valid || wb_data == '0, "R6 data zero outside pulse", {32'd0, wb_data}, 64'd0);
      req_valid = stray && (i < e) && ($urandom_range(0, 3) == 0);
      if (req_valid) begin req_op_hi = ~kh; req_funct3 = ~f3; req_funct7 = ~f7; end
      trap_i    = (i == tr);
      cp_valid  = (i == d) ? NUM_CP'($urandom_range(1, (1 << NUM_CP) - 1)) : '0;
      cp_result = '0;
      if (d >= 0 && i == d + 1) begin
        cp_result[0 +: W]   = data & m0;
        cp_result[W +: W]   = data & m1;
        cp_result[2*W +: W] = data & ~m0 & ~m1;
      end
    end
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle_inputs();
    req_op_hi = '0; req_funct3 = '0; req_funct7 = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !cp_start && !wb_valid && !exc_illegal && req_ready && wb_data == '0,
        "R11 reset state", {59'd0, busy, cp_start, wb_valid, exc_illegal, req_ready}, 64'd1);
    rst_n = 1'b1;

    // R10: valid and data while idle are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cp_valid = '1; cp_result = {NUM_CP{32'hDEAD_BEEF}};
      if (i > 1) chk(!busy && !wb_valid && !exc_illegal, "R10 idle valid ignored",
                     {61'd0, busy, wb_valid, exc_illegal}, 64'd0);
    end
    idle_inputs();
    repeat (3) @(negedge clk);
    chk(!wb_valid && !busy, "R10 no late write-back", {62'd0, wb_valid, busy}, 64'd0);

    // Directed corner cases
    do_op(2'b00, 3'd0, 7'h00, 0, -1, 32'h1234_5678, 1'b0);           // R4 immediate valid
    do_op(2'b01, 3'd1, 7'h55, 1, -1, 32'hFFFF_0000, 1'b1);           // R3 kind 01, R1 stray
    do_op(2'b10, 3'd7, 7'h7F, LIMIT - 1, -1, 32'hA5A5_5A5A, 1'b0);   // R12 last window cycle
    do_op(2'b11, 3'd2, 7'h01, -1, -1, 32'h0, 1'b1);                  // R7 timeout
    do_op(2'b00, 3'd3, 7'h11, LIMIT, -1, 32'hCAFE_F00D, 1'b0);       // R7/R10 late valid
    do_op(2'b01, 3'd4, 7'h22, 5, 0, 32'h1111_1111, 1'b0);            // R9 trap in strobe cycle
    do_op(2'b10, 3'd5, 7'h33, 3, 4, 32'h2222_2222, 1'b0);            // R9 trap in capture cycle
    do_op(2'b11, 3'd6, 7'h44, 3, 5, 32'h3333_3333, 1'b0);            // R9/R10 trap after end
    do_op(2'b00, 3'd0, 7'h00, LIMIT - 1, LIMIT, 32'h4444_4444, 1'b0);// R9 trap at final capture

    // Constrained random operations
    for (int n = 0; n < 60; n++) begin
      int d  = ($urandom_range(0, 15) == 0) ? -1 : int'($urandom_range(0, 40));
      int tr = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 42)) : -1;
      do_op(2'($urandom), 3'($urandom), 7'($urandom), d, tr, $urandom, 1'b1);
    end

    // R11: asynchronous reset mid-operation
    @(negedge clk);
    req_valid = 1'b1; req_op_hi = 2'b01;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy before reset", {63'd0, busy}, 64'd1);
    #0.5 rst_n = 1'b0;
    #0.5;
    chk(!busy && !cp_start && req_ready, "R11 asynchronous clear",
        {61'd0, busy, cp_start, req_ready}, 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    do_op(2'b10, 3'd1, 7'h0F, 2, -1, 32'h0BAD_F00D, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule